// File: doc/BRIEF.md
# Instruction Machine Cycle Sequencer

This block sits one level above the bus cycle generator of a small 8-bit processor. When an instruction class is presented with a start strobe, it issues the machine cycles that instruction needs, one at a time and in order. Each cycle carries a type code, the source of its address and its length in T-states. The bus unit runs each cycle and answers with a one-cycle done handshake. Only then does the sequencer present the next cycle.

After the last cycle of the sequence, the block pulses an instruction-complete flag. At the same moment it presents the exact total number of T-states that the instruction used. The covered classes are:

- plain 8-bit register operations;
- 16-bit internal operations with a stretched fetch;
- immediate loads;
- direct stores;
- register-pair adds that spend two idle bus cycles;
- interrupt-driven restart and call, which start with acknowledge fetches instead of an opcode fetch.

Top module: `mcyc_sequencer`

## Requirements
- R1: The first cycle of every sequence is an opcode fetch (type 3'b011) for classes 0 to 4, and an interrupt-acknowledge fetch (type 3'b111) for classes 5 and 6.
- R2: Class 0 (8-bit register operation) issues one opcode fetch of 4 T-states from address source PC (0), total 4.
- R3: Class 1 (16-bit internal operation) issues one opcode fetch of 6 T-states from PC, total 6.
- R4: Class 2 (immediate load) issues a 4-T-state fetch from PC, then one memory read (type 3'b010) of 3 T-states from source next-PC (1), total 7.
- R5: Class 3 (direct store) issues a 4-T-state fetch, two 3-T-state memory reads from next-PC (low then high address byte), then a 3-T-state memory write (type 3'b001) from source temporary register (2), total 13.
- R6: Class 4 (register-pair add) issues a 4-T-state fetch, then two idle cycles (type 3'b000) of 3 T-states each with source none (7), total 10.
- R7: Class 5 (interrupt restart) issues a 6-T-state acknowledge fetch from PC, then two 3-T-state memory writes: first at stack-pointer-minus-1 (source 3), then at stack-pointer-minus-2 (source 4), total 12.
- R8: Class 6 (interrupt call) issues a 6-T-state acknowledge fetch from PC, two 3-T-state acknowledge fetches from next-PC, then the writes to stack-pointer-minus-1 and stack-pointer-minus-2, total 18.
- R9: A presented cycle holds its type, source and length, with cyc_valid high, until cyc_done is sampled. The next cycle appears in the following clock.
- R10: instr_done is a one-cycle pulse in the clock after the last cycle's cyc_done. While it is high, cyc_valid is low and t_total equals the instruction's T-state total.
- R11: A start while a sequence runs does not disturb it. A start with reserved class 7 starts nothing: cyc_valid and instr_done stay low.
- R12: After reset, cyc_valid and instr_done are low, cyc_kind is 3'b000, cyc_src is 7 and t_total is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence for iclass when idle |
| iclass | input | 3 | Instruction class code, 0 to 6 |
| cyc_done | input | 1 | Bus unit finished the presented cycle |
| cyc_valid | output | 1 | A machine cycle is being presented |
| cyc_kind | output | 3 | Machine cycle type / status code |
| cyc_src | output | 3 | Address source of the presented cycle |
| cyc_tlen | output | 3 | T-states of the presented cycle |
| instr_done | output | 1 | One-cycle pulse when the instruction completes |
| t_total | output | 6 | T-state total of the last (or running) instruction |

## Verification
Each class is first driven directly with immediate handshakes. This shows that the sequence order and totals are right when no waiting is involved. Random streams of classes then follow, with 0 to 2 clocks of delay before each handshake. These separate a cycle that is held correctly from one that advances on its own, and they catch totals summed over the wrong steps. Starts injected during a running sequence, and the reserved class code, show whether the sequencer takes a request it must ignore.

// File: rtl/mcyc_pkg.sv
// Shared types for the machine cycle sequencer.
// Assumes the bus unit decodes the cycle type as a 3-bit status code.
package mcyc_pkg;

    localparam int KIND_W     = 3;
    localparam int SRC_W      = 3;
    localparam int TLEN_W     = 3;
    localparam int NUM_CLASSES = 7;

    typedef enum logic [KIND_W-1:0] {
        K_IDLE  = 3'b000,
        K_MWR   = 3'b001,
        K_MRD   = 3'b010,
        K_FETCH = 3'b011,
        K_IACK  = 3'b111
    } kind_e;

    typedef enum logic [SRC_W-1:0] {
        S_PC   = 3'd0,
        S_PCN  = 3'd1,
        S_TMP  = 3'd2,
        S_SPM1 = 3'd3,
        S_SPM2 = 3'd4,
        S_NONE = 3'd7
    } src_e;

    typedef struct packed {
        kind_e             kind;
        src_e              src;
        logic [TLEN_W-1:0] tlen;
        logic              last;
    } step_t;

    function automatic step_t mk_step(kind_e k, src_e s, logic [TLEN_W-1:0] t, logic l);
        step_t r;
        r.kind = k;
        r.src  = s;
        r.tlen = t;
        r.last = l;
        return r;
    endfunction

endpackage

// File: rtl/mcyc_steps.sv
// Step table: maps (class, step index) to one machine cycle descriptor.
// Assumes class codes 0..6; any other code or index gives a harmless last idle step.
module mcyc_steps
    import mcyc_pkg::*;
#(
    parameter int CLS_W = 3,
    parameter int IDX_W = 3
) (
    input  logic [CLS_W-1:0] cls,
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    // Purpose: combinational lookup of the current cycle descriptor.
    always_comb begin
        step = mk_step(K_IDLE, S_NONE, 3'd0, 1'b1);
        unique case (cls)
            3'd0: step = mk_step(K_FETCH, S_PC, 3'd4, 1'b1);
            3'd1: step = mk_step(K_FETCH, S_PC, 3'd6, 1'b1);
            3'd2: case (idx)
                      3'd0:    step = mk_step(K_FETCH, S_PC,  3'd4, 1'b0);
                      default: step = mk_step(K_MRD,   S_PCN, 3'd3, 1'b1);
                  endcase
            3'd3: case (idx)
                      3'd0:    step = mk_step(K_FETCH, S_PC,  3'd4, 1'b0);
                      3'd1,
                      3'd2:    step = mk_step(K_MRD,   S_PCN, 3'd3, 1'b0);
                      default: step = mk_step(K_MWR,   S_TMP, 3'd3, 1'b1);
                  endcase
            3'd4: case (idx)
                      3'd0:    step = mk_step(K_FETCH, S_PC,   3'd4, 1'b0);
                      3'd1:    step = mk_step(K_IDLE,  S_NONE, 3'd3, 1'b0);
                      default: step = mk_step(K_IDLE,  S_NONE, 3'd3, 1'b1);
                  endcase
            3'd5: case (idx)
                      3'd0:    step = mk_step(K_IACK, S_PC,   3'd6, 1'b0);
                      3'd1:    step = mk_step(K_MWR,  S_SPM1, 3'd3, 1'b0);
                      default: step = mk_step(K_MWR,  S_SPM2, 3'd3, 1'b1);
                  endcase
            3'd6: case (idx)
                      3'd0:    step = mk_step(K_IACK, S_PC,   3'd6, 1'b0);
                      3'd1,
                      3'd2:    step = mk_step(K_IACK, S_PCN,  3'd3, 1'b0);
                      3'd3:    step = mk_step(K_MWR,  S_SPM1, 3'd3, 1'b0);
                      default: step = mk_step(K_MWR,  S_SPM2, 3'd3, 1'b1);
                  endcase
            default: step = mk_step(K_IDLE, S_NONE, 3'd0, 1'b1);
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl.sv
// Sequence control: accepts a start when idle, latches the class, steps the
// index on each bus handshake and raises a one-cycle finish pulse.
// Assumes cyc_done is a single-cycle pulse from the bus unit.
module mcyc_ctrl
    import mcyc_pkg::*;
#(
    parameter int CLS_W = 3,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CLS_W-1:0] cls_in,
    input  logic             cyc_done,
    input  logic             last,
    output logic             busy,
    output logic             accept,
    output logic [CLS_W-1:0] cls_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             fin
);

    logic cls_ok;

    // Purpose: decide whether a start request may open a sequence.
    always_comb begin
        cls_ok = (int'(cls_in) < NUM_CLASSES);
        accept = start && !busy && cls_ok;
    end

    // Purpose: run/idle state, class latch, step index and finish pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cls_q <= '0;
            idx_q <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                cls_q <= cls_in;
                idx_q <= '0;
            end else if (busy && cyc_done) begin
                if (last) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cyc_done |=> busy && $stable(idx_q)); // R9

    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin); // R10

    AST_CLASS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !(cyc_done && last) |=> busy && $stable(cls_q)); // R11

endmodule

// File: rtl/mcyc_tally.sv
// T-state accumulator: cleared when a sequence opens, adds each finished
// cycle's length. Assumes TOT_W is wide enough for the longest sequence.
module mcyc_tally
    import mcyc_pkg::*;
#(
    parameter int TOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [TLEN_W-1:0] tlen,
    output logic [TOT_W-1:0]  total
);

    // Purpose: hold the running T-state sum of the current instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (clear) begin
            total <= '0;
        end else if (add) begin
            total <= total + TOT_W'(tlen);
        end
    end

    AST_SUM_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        add && !clear |=> total > $past(total)); // R10

endmodule

// File: rtl/mcyc_sequencer.sv
// Top: turns an instruction class into its ordered machine cycles and
// reports the exact T-state total. Assumes the bus unit handshakes every
// presented cycle with a one-cycle cyc_done.
module mcyc_sequencer
    import mcyc_pkg::*;
#(
    parameter int CLS_W = 3,
    parameter int IDX_W = 3,
    parameter int TOT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CLS_W-1:0] iclass,
    input  logic             cyc_done,
    output logic             cyc_valid,
    output logic [2:0]       cyc_kind,
    output logic [2:0]       cyc_src,
    output logic [2:0]       cyc_tlen,
    output logic             instr_done,
    output logic [TOT_W-1:0] t_total
);

    logic             busy;
    logic             accept;
    logic [CLS_W-1:0] cls_q;
    logic [IDX_W-1:0] idx_q;
    step_t            step;

    mcyc_ctrl #(.CLS_W(CLS_W), .IDX_W(IDX_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cls_in   (iclass),
        .cyc_done (cyc_done),
        .last     (step.last),
        .busy     (busy),
        .accept   (accept),
        .cls_q    (cls_q),
        .idx_q    (idx_q),
        .fin      (instr_done)
    );

    mcyc_steps #(.CLS_W(CLS_W), .IDX_W(IDX_W)) i_steps (
        .cls  (cls_q),
        .idx  (idx_q),
        .step (step)
    );

    mcyc_tally #(.TOT_W(TOT_W)) i_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .add   (busy && cyc_done),
        .tlen  (step.tlen),
        .total (t_total)
    );

    // Purpose: present the current cycle, or a quiet idle code when not running.
    always_comb begin
        cyc_valid = busy;
        cyc_kind  = busy ? step.kind : K_IDLE;
        cyc_src   = busy ? step.src  : S_NONE;
        cyc_tlen  = busy ? step.tlen : 3'd0;
    end

    AST_FIRST_IS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_valid) |-> (cyc_kind == K_FETCH || cyc_kind == K_IACK)); // R1

    AST_IDLE_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && cyc_kind == K_IDLE |-> cyc_src == S_NONE && cyc_tlen == 3'd3); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> !cyc_valid); // R10

    AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && !cyc_done |=> $stable(cyc_kind) && $stable(cyc_src) && $stable(cyc_tlen)); // R9

endmodule

// File: tb/test_mcyc_sequencer.sv
module test_mcyc_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] iclass = 3'd0;
    logic       cyc_done = 1'b0;
    logic       cyc_valid;
    logic [2:0] cyc_kind;
    logic [2:0] cyc_src;
    logic [2:0] cyc_tlen;
    logic       instr_done;
    logic [5:0] t_total;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mcyc_sequencer i_mcyc_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .iclass     (iclass),
        .cyc_done   (cyc_done),
        .cyc_valid  (cyc_valid),
        .cyc_kind   (cyc_kind),
        .cyc_src    (cyc_src),
        .cyc_tlen   (cyc_tlen),
        .instr_done (instr_done),
        .t_total    (t_total)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected step count per class, from the requirements.
    function automatic int exp_len(input logic [2:0] c);
        case (c)
            3'd0, 3'd1: return 1;
            3'd2:       return 2;
            3'd3:       return 4;
            3'd4, 3'd5: return 3;
            3'd6:       return 5;
            default:    return 0;
        endcase
    endfunction

    // Expected total T-states per class.
    function automatic int exp_total(input logic [2:0] c);
        case (c)
            3'd0: return 4;   3'd1: return 6;   3'd2: return 7;
            3'd3: return 13;  3'd4: return 10;  3'd5: return 12;
            3'd6: return 18;  default: return 0;
        endcase
    endfunction

    // Expected {kind, src, tlen} of step i for class c.
    function automatic logic [8:0] exp_step(input logic [2:0] c, input int i);
        case (c)
            3'd0: return {3'b011, 3'd0, 3'd4};
            3'd1: return {3'b011, 3'd0, 3'd6};
            3'd2: return (i == 0) ? {3'b011, 3'd0, 3'd4} : {3'b010, 3'd1, 3'd3};
            3'd3: return (i == 0) ? {3'b011, 3'd0, 3'd4} :
                         (i < 3)  ? {3'b010, 3'd1, 3'd3} : {3'b001, 3'd2, 3'd3};
            3'd4: return (i == 0) ? {3'b011, 3'd0, 3'd4} : {3'b000, 3'd7, 3'd3};
            3'd5: return (i == 0) ? {3'b111, 3'd0, 3'd6} :
                         (i == 1) ? {3'b001, 3'd3, 3'd3} : {3'b001, 3'd4, 3'd3};
            default: return (i == 0) ? {3'b111, 3'd0, 3'd6} :
                            (i < 3)  ? {3'b111, 3'd1, 3'd3} :
                            (i == 3) ? {3'b001, 3'd3, 3'd3} : {3'b001, 3'd4, 3'd3};
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4";
            3'd3: return "R5"; 3'd4: return "R6"; 3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run_instr(input logic [2:0] c, input bit inject, input int maxwait);
        int sum = 0;
        @(negedge clk);
        iclass = c;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        iclass = 3'($urandom);
        if (c == 3'd7) begin
            chk(cyc_valid == 1'b0, "R11 reserved class", int'(cyc_valid), 0);
            @(negedge clk);
            chk(cyc_valid == 1'b0 && instr_done == 1'b0, "R11 reserved class later",
                int'(cyc_valid), 0);
            return;
        end
        if (inject) begin
            start  = 1'b1;
            iclass = c ^ 3'd1;
            @(negedge clk);
            start  = 1'b0;
        end
        for (int i = 0; i < exp_len(c); i++) begin
            int d = (maxwait > 0) ? int'($urandom % (maxwait + 1)) : 0;
            logic [8:0] e = exp_step(c, i);
            for (int w = 0; w <= d; w++) begin
                chk(cyc_valid == 1'b1, "R9 valid held", int'(cyc_valid), 1);
                if (i == 0)
                    chk(cyc_kind == e[8:6], "R1 first cycle type", int'(cyc_kind), int'(e[8:6]));
                chk(cyc_kind == e[8:6], req_of(c), int'(cyc_kind), int'(e[8:6]));
                chk(cyc_src == e[5:3], req_of(c), int'(cyc_src), int'(e[5:3]));
                chk(cyc_tlen == e[2:0], req_of(c), int'(cyc_tlen), int'(e[2:0]));
                chk(instr_done == 1'b0, "R10 no early done", int'(instr_done), 0);
                if (w < d) @(negedge clk);
            end
            sum += int'(e[2:0]);
            cyc_done = 1'b1;
            @(negedge clk);
            cyc_done = 1'b0;
        end
        chk(sum == exp_total(c), req_of(c), sum, exp_total(c));
        chk(instr_done == 1'b1, "R10 done pulse", int'(instr_done), 1);
        chk(int'(t_total) == exp_total(c), "R10 total", int'(t_total), exp_total(c));
        chk(cyc_valid == 1'b0, "R10 quiet at done", int'(cyc_valid), 0);
        @(negedge clk);
        chk(instr_done == 1'b0, "R10 pulse width", int'(instr_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_0D85));
        repeat (3) @(negedge clk);
        chk(cyc_valid == 1'b0, "R12 valid", int'(cyc_valid), 0);
        chk(instr_done == 1'b0, "R12 done", int'(instr_done), 0);
        chk(cyc_kind == 3'b000, "R12 kind", int'(cyc_kind), 0);
        chk(cyc_src == 3'd7, "R12 src", int'(cyc_src), 7);
        chk(t_total == 6'd0, "R12 total", int'(t_total), 0);
        rst_n = 1'b1;
        // Directed: every class with immediate handshakes, then with waits.
        for (int c = 0; c < 8; c++) run_instr(3'(c), 1'b0, 0);
        for (int c = 0; c < 7; c++) run_instr(3'(c), 1'b1, 2);
        // Random stream.
        for (int n = 0; n < 400; n++)
            run_instr(3'($urandom % 8), 1'($urandom % 4 == 0), 2);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule